// File: doc/BRIEF.md
# External Interrupt Conditioning Unit

This block takes a bank of asynchronous external interrupt pins and turns each one into a clean, active-high request for a downstream interrupt controller. Each pin is conditioned on its own. It is first brought into the local clock domain. It is then treated either as a level or as an edge, with a polarity chosen for that line. Edge events are held in a sticky request bit until software clears it. A per-line mask decides whether the request reaches the line's own output.

Software controls the unit through a small word-wide register bus with one bit per line in every register. It can read the raw request before masking and the request after masking. It writes ones to discard held edge events. The usual sequence is to clear stale events first and then unmask. Two further registers, a source-select word and a software-request word, are plain storage that reads back what was written.

Top module: `eicu_top`

## Requirements
- R1: After reset every mask bit is 1, the polarity, edge-select, source-select and software-request registers read 0, no edge request is held, and every irq_o bit is 0.
- R2: Each input passes two synchronising flops: in level mode a pin change driven between clock edges reaches irq_o after the second rising clock edge, and not after the first.
- R3: In level mode (edge bit 0) the raw request equals the synchronised pin when the polarity bit is 1, and its inverse when the polarity bit is 0.
- R4: In edge mode (edge bit 1) a 0-to-1 pin transition sets the held request when polarity is 1, a 1-to-0 transition sets it when polarity is 0, the other transition sets nothing, and the request stays set after the pin returns.
- R5: Masked status equals raw status AND NOT mask, irq_o equals masked status, and a line whose mask bit is 1 drives 0 on irq_o from the cycle after that mask bit is written.
- R6: Writing a 1 to a bit of the clear register (byte offset 0x10) drops that line's held request, writing 0 leaves it unchanged, and reading offset 0x10 returns 0.
- R7: When an edge event and a clear of the same line arrive in the same clock cycle, the held request ends up set.
- R8: Edge requests are held while their line is masked, are presented on irq_o when the line is unmasked, and do not appear if they are cleared before unmasking.
- R9: Byte offsets: 0x00 mask, 0x04 source select, 0x08 masked status, 0x0C raw status, 0x10 clear, 0x14 polarity, 0x18 edge select, 0x1C software request; source select and software request read back the written value and do not affect irq_o, and writes to the two status offsets are ignored.
- R10: A read strobe returns data on bus_rdata_o with bus_rvalid_o high for exactly the next cycle; offsets above 0x1C, or with address bits [1:0] not zero, read as 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_irq_i | input | N_LINES | Asynchronous external interrupt pins |
| bus_req_i | input | 1 | Bus access strobe, one cycle per access |
| bus_we_i | input | 1 | 1 for write, 0 for read |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | N_LINES | Write data, one bit per line |
| bus_rdata_o | output | N_LINES | Read data, valid with bus_rvalid_o |
| bus_rvalid_o | output | 1 | High for one cycle after a read strobe |
| irq_o | output | N_LINES | Active-high conditioned requests, one per line |

## Verification
The bench aims a clear write at the exact cycle in which a new edge is detected; a design that lets the clear win would lose a real interrupt and read back 0 where 1 is expected. It checks the synchroniser latency cycle by cycle, so a design with one stage too few or too many shows the output one cycle early or late. Falling-edge lines get a rising transition that must not latch, and a pending event that is cleared before unmasking must never reach irq_o. Writes of zero to the clear register, writes to the read-only status words, and misaligned or unmapped offsets are each followed by read-backs showing nothing changed.

// File: rtl/eicu_pkg.sv
package eicu_pkg;

  // Word indices of the register offsets (byte offset / 4)
  localparam int unsigned WI_MASK   = 0;
  localparam int unsigned WI_SRCSEL = 1;
  localparam int unsigned WI_MSTAT  = 2;
  localparam int unsigned WI_RAW    = 3;
  localparam int unsigned WI_CLR    = 4;
  localparam int unsigned WI_POL    = 5;
  localparam int unsigned WI_EDGE   = 6;
  localparam int unsigned WI_SOFT   = 7;
  localparam int unsigned WI_COUNT  = 8;

  // Edge event for one line: a transition in the direction named by polarity
  function automatic logic edge_event(input logic pol, input logic cur, input logic prev);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction

  // Raw request for one line before masking
  function automatic logic raw_request(input logic edge_sel, input logic pol,
                                       input logic lvl, input logic held);
    return edge_sel ? held : (pol ? lvl : ~lvl);
  endfunction

  // Next state of the held edge request: a new event beats a clear
  function automatic logic next_held(input logic held, input logic clr, input logic set);
    return (held & ~clr) | set;
  endfunction

endpackage

// File: rtl/eicu_sync.sv
module eicu_sync #(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned STAGES  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] async_i,
  output logic [N_LINES-1:0] sync_o
);

  logic [N_LINES-1:0] stg_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q[0] <= '0;
    else        stg_q[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[s] <= '0;
      else        stg_q[s] <= stg_q[s-1];
    end
  end

  assign sync_o = stg_q[STAGES-1];

endmodule

// File: rtl/eicu_line.sv
module eicu_line
  import eicu_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic pol_i,
  input  logic edge_sel_i,
  input  logic mask_i,
  input  logic clr_i,
  output logic raw_o,
  output logic masked_o
);

  logic prev_q;
  logic held_q;
  logic evt_w;
  logic set_w;

  assign evt_w = edge_event(pol_i, lvl_i, prev_q);
  assign set_w = edge_sel_i & evt_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      held_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      held_q <= next_held(held_q, clr_i, set_w);
    end
  end

  assign raw_o    = raw_request(edge_sel_i, pol_i, lvl_i, held_q);
  assign masked_o = raw_o & ~mask_i;

  // R4 R7
  edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_w |=> held_q);

  // R6
  clear_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_w) |=> !held_q);

  // R8
  held_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !clr_i) |=> held_q);

endmodule

// File: rtl/eicu_regs.sv
module eicu_regs
  import eicu_pkg::*;
#(
  parameter int unsigned N_LINES = 32,
  parameter int unsigned ADDR_W  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_req_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [N_LINES-1:0] bus_wdata_i,
  output logic [N_LINES-1:0] bus_rdata_o,
  output logic               bus_rvalid_o,
  input  logic [N_LINES-1:0] raw_i,
  input  logic [N_LINES-1:0] masked_i,
  output logic [N_LINES-1:0] mask_o,
  output logic [N_LINES-1:0] pol_o,
  output logic [N_LINES-1:0] edge_o,
  output logic [N_LINES-1:0] clr_o
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]   idx_w;
  logic               aligned_w;
  logic               mapped_w;
  logic               wr_w;
  logic               rd_w;
  logic [N_LINES-1:0] rmux_w;

  logic [N_LINES-1:0] mask_q, srcsel_q, pol_q, edge_q, soft_q;
  logic [N_LINES-1:0] rdata_q;
  logic               rvalid_q;

  assign idx_w     = bus_addr_i[ADDR_W-1:2];
  assign aligned_w = (bus_addr_i[1:0] == 2'b00);
  assign mapped_w  = aligned_w && (idx_w < IDX_W'(WI_COUNT));
  assign wr_w      = bus_req_i &  bus_we_i & mapped_w;
  assign rd_w      = bus_req_i & ~bus_we_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '1;
      srcsel_q <= '0;
      pol_q    <= '0;
      edge_q   <= '0;
      soft_q   <= '0;
    end else if (wr_w) begin
      case (idx_w)
        IDX_W'(WI_MASK):   mask_q   <= bus_wdata_i;
        IDX_W'(WI_SRCSEL): srcsel_q <= bus_wdata_i;
        IDX_W'(WI_POL):    pol_q    <= bus_wdata_i;
        IDX_W'(WI_EDGE):   edge_q   <= bus_wdata_i;
        IDX_W'(WI_SOFT):   soft_q   <= bus_wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_o = (wr_w && idx_w == IDX_W'(WI_CLR)) ? bus_wdata_i : '0;

  always_comb begin
    rmux_w = '0;
    if (mapped_w) begin
      case (idx_w)
        IDX_W'(WI_MASK):   rmux_w = mask_q;
        IDX_W'(WI_SRCSEL): rmux_w = srcsel_q;
        IDX_W'(WI_MSTAT):  rmux_w = masked_i;
        IDX_W'(WI_RAW):    rmux_w = raw_i;
        IDX_W'(WI_POL):    rmux_w = pol_q;
        IDX_W'(WI_EDGE):   rmux_w = edge_q;
        IDX_W'(WI_SOFT):   rmux_w = soft_q;
        default:           rmux_w = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_w;
      if (rd_w) rdata_q <= rmux_w;
    end
  end

  assign bus_rdata_o  = rdata_q;
  assign bus_rvalid_o = rvalid_q;
  assign mask_o       = mask_q;
  assign pol_o        = pol_q;
  assign edge_o       = edge_q;

  // R10
  rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_w |=> bus_rvalid_o);

  // R10
  rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_w |=> !bus_rvalid_o);

  // R6
  clr_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_w && aligned_w && idx_w == IDX_W'(WI_CLR)) |=> (bus_rdata_o == '0));

endmodule

// File: rtl/eicu_top.sv
module eicu_top
  import eicu_pkg::*;
#(
  parameter int unsigned N_LINES     = 32,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] ext_irq_i,
  input  logic               bus_req_i,
  input  logic               bus_we_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic [N_LINES-1:0] bus_wdata_i,
  output logic [N_LINES-1:0] bus_rdata_o,
  output logic               bus_rvalid_o,
  output logic [N_LINES-1:0] irq_o
);

  localparam logic [ADDR_W-1:0] MASK_ADDR = ADDR_W'(WI_MASK * 4);

  logic [N_LINES-1:0] lvl_w;
  logic [N_LINES-1:0] raw_w;
  logic [N_LINES-1:0] masked_w;
  logic [N_LINES-1:0] mask_w, pol_w, edge_w, clr_w;
  logic               mask_wr_w;

  eicu_sync #(.N_LINES(N_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (ext_irq_i),
    .sync_o  (lvl_w)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    eicu_line u_line (
      .clk        (clk),
      .rst_n      (rst_n),
      .lvl_i      (lvl_w[i]),
      .pol_i      (pol_w[i]),
      .edge_sel_i (edge_w[i]),
      .mask_i     (mask_w[i]),
      .clr_i      (clr_w[i]),
      .raw_o      (raw_w[i]),
      .masked_o   (masked_w[i])
    );
  end

  eicu_regs #(.N_LINES(N_LINES), .ADDR_W(ADDR_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_req_i    (bus_req_i),
    .bus_we_i     (bus_we_i),
    .bus_addr_i   (bus_addr_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_rdata_o  (bus_rdata_o),
    .bus_rvalid_o (bus_rvalid_o),
    .raw_i        (raw_w),
    .masked_i     (masked_w),
    .mask_o       (mask_w),
    .pol_o        (pol_w),
    .edge_o       (edge_w),
    .clr_o        (clr_w)
  );

  assign irq_o = masked_w;

  assign mask_wr_w = bus_req_i && bus_we_i && (bus_addr_i == MASK_ADDR);

  // R5
  mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr_w |=> ((irq_o & $past(bus_wdata_i)) == '0));

endmodule

// File: tb/tb_eicu_top.sv
module tb_eicu_top;

  localparam int N  = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  ext;
  logic          req, we;
  logic [AW-1:0] addr;
  logic [N-1:0]  wdata;
  logic [N-1:0]  rdata;
  logic          rvalid;
  logic [N-1:0]  irq;

  int tests = 0;
  int fails = 0;

  typedef struct {
    logic [N-1:0] exp;
    string        tag;
  } rd_item_t;
  rd_item_t sbq[$];

  localparam logic [AW-1:0] A_MASK = 6'h00, A_SRC = 6'h04, A_MST = 6'h08,
                            A_RAW = 6'h0C, A_CLR = 6'h10, A_POL = 6'h14,
                            A_EDG = 6'h18, A_SOFT = 6'h1C;

  always #2 clk = ~clk;

  eicu_top dut (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(ext),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [AW-1:0] a, input logic [N-1:0] d);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [AW-1:0] a, input logic [N-1:0] exp, input string tag);
    rd_item_t it;
    it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
  endtask

  // Monitor: pops an expected item for every returned read
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && rvalid) begin
        if (sbq.size() == 0) begin
          tests++; fails++;
          $display("FAIL R10: unexpected read return %h expected none", rdata);
        end else begin
          rd_item_t it;
          it = sbq.pop_front();
          chk(it.tag, rdata, it.exp);
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext = '0; req = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    idle(5);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    chk("R1 irq after reset", irq, '0);
    bus_read(A_MASK, 32'hFFFF_FFFF, "R1 mask reset");
    bus_read(A_POL,  32'h0, "R1 polarity reset");
    bus_read(A_EDG,  32'h0, "R1 edge reset");
    bus_read(A_SRC,  32'h0, "R1 srcsel reset");
    bus_read(A_SOFT, 32'h0, "R1 soft reset");
    bus_read(A_RAW,  32'hFFFF_FFFF, "R3 active-low level, pins low");
    bus_read(A_MST,  32'h0, "R5 masked status all masked");

    // R10 unmapped and misaligned, R6 clear reads 0
    bus_read(6'h20, 32'h0, "R10 unmapped read");
    bus_read(6'h3C, 32'h0, "R10 unmapped top read");
    bus_write(6'h01, 32'h0);  // misaligned mask write ignored
    bus_read(6'h01, 32'h0, "R10 misaligned read");
    bus_read(A_MASK, 32'hFFFF_FFFF, "R10 misaligned write ignored");
    bus_read(A_CLR, 32'h0, "R6 clear reads zero");

    // R9 storage registers and read-only status
    bus_write(A_SRC, 32'h1234_5678);
    bus_write(A_SOFT, 32'hCAFE_0001);
    bus_write(A_RAW, 32'h0000_DEAD);
    bus_write(A_MST, 32'h0000_BEEF);
    bus_read(A_SRC, 32'h1234_5678, "R9 srcsel readback");
    bus_read(A_SOFT, 32'hCAFE_0001, "R9 soft readback");
    bus_read(A_RAW, 32'hFFFF_FFFF, "R9 raw write ignored");
    chk("R9 storage has no output effect", irq, '0);

    // R3 level high, R2 synchroniser latency
    bus_write(A_POL, 32'hFFFF_FFFF);
    bus_write(A_MASK, 32'h0);
    bus_read(A_RAW, 32'h0, "R3 active-high level, pins low");
    ext[0] = 1'b1;
    @(negedge clk);
    chk("R2 not after first edge", irq, 32'h0);
    @(negedge clk);
    chk("R2 after second edge", irq, 32'h1);
    ext = 32'h0000_00A5;
    idle(4);
    chk("R3 level high irq", irq, 32'h0000_00A5);
    bus_read(A_RAW, 32'h0000_00A5, "R3 level high raw");

    // R5 masking
    bus_write(A_MASK, 32'h0000_000F);
    chk("R5 irq masked", irq, 32'h0000_00A0);
    bus_read(A_MST, 32'h0000_00A0, "R5 masked status");
    bus_read(A_RAW, 32'h0000_00A5, "R5 raw unaffected by mask");

    // R3 active-low on low byte
    bus_write(A_POL, 32'hFFFF_FF00);
    bus_read(A_RAW, 32'h0000_005A, "R3 active-low level raw");
    chk("R3 active-low irq", irq, 32'h0000_0050);

    // R4 rising edge
    bus_write(A_MASK, 32'h0);
    bus_write(A_POL, 32'hFFFF_FFFF);
    ext = '0;
    idle(4);
    bus_write(A_EDG, 32'hFFFF_FFFF);
    bus_write(A_CLR, 32'hFFFF_FFFF);
    bus_read(A_RAW, 32'h0, "R4 edge mode idle");
    ext[3] = 1'b1;
    idle(4);
    bus_read(A_RAW, 32'h0000_0008, "R4 rising latched");
    ext[3] = 1'b0;
    idle(4);
    bus_read(A_RAW, 32'h0000_0008, "R4 latch sticky");
    chk("R4 latched irq", irq, 32'h0000_0008);

    // R6 write-one-to-clear
    bus_write(A_CLR, 32'h0);
    bus_read(A_RAW, 32'h0000_0008, "R6 zero write no effect");
    bus_write(A_CLR, 32'h0000_0008);
    bus_read(A_RAW, 32'h0, "R6 one clears");
    chk("R6 irq after clear", irq, 32'h0);

    // R4 falling edge on line 5
    ext[5] = 1'b1;
    idle(4);
    bus_write(A_CLR, 32'h0000_0020);
    bus_write(A_POL, 32'hFFFF_FFDF);
    idle(2);
    ext[5] = 1'b0;
    idle(4);
    bus_read(A_RAW, 32'h0000_0020, "R4 falling latched");
    bus_write(A_CLR, 32'h0000_0020);
    ext[5] = 1'b1;
    idle(4);
    bus_read(A_RAW, 32'h0, "R4 rising ignored on falling line");

    // R8 latched while masked, discard before unmask
    bus_write(A_MASK, 32'h0000_0200);
    ext[9] = 1'b1;
    idle(4);
    chk("R8 masked no irq", irq, 32'h0);
    bus_read(A_RAW, 32'h0000_0200, "R8 raw pending while masked");
    bus_read(A_MST, 32'h0, "R8 masked status hidden");
    bus_write(A_CLR, 32'h0000_0200);
    bus_write(A_MASK, 32'h0);
    chk("R8 discarded before unmask", irq, 32'h0);
    ext[9] = 1'b0;
    bus_write(A_MASK, 32'h0000_0200);
    idle(3);
    ext[9] = 1'b1;
    idle(4);
    bus_write(A_MASK, 32'h0);
    chk("R8 pending delivered on unmask", irq, 32'h0000_0200);
    bus_write(A_CLR, 32'h0000_0200);
    chk("R8 cleared after delivery", irq, 32'h0);

    // R7 clear in the same cycle as a new edge
    ext[12] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    bus_write(A_CLR, 32'h0000_1000);
    idle(2);
    bus_read(A_RAW, 32'h0000_1000, "R7 edge beats clear");
    bus_write(A_CLR, 32'h0000_1000);
    bus_read(A_RAW, 32'h0, "R7 later clear works");

    idle(4);
    chk("R10 scoreboard drained", 32'(sbq.size()), 32'h0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule